// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Selectable Output Latency

This block is a true dual-port synchronous memory. Two ports, called left and right, reach one shared storage array, and each may read or write any word at any time, including the same word in the same cycle. Each port registers its address, write data and controls on the rising clock edge. An address counter sits in front of each port. The counter can take an external address, step to the next word, or clear to word zero, so software can walk a burst without presenting every address.

Each port has its own latency setting. In flow-through mode, read data appears after the edge that captured the address. In pipelined mode, the data passes through one more register.

A port acts only when its two chip selects are in their active states, one active low and one active high. The output stage is modelled as a data bus plus a drive flag, which stands in for a tri-state pad. The flag drops when the port is deselected or when the asynchronous output-disable input is high. Both ports share one clock, which gives a same-edge write collision a precise meaning: the left port wins and a collision flag is raised.

Top module: `dpram_top`

## Requirements
- R1: A port is selected only when its `*_cs_n` is 0 and its `*_cs` is 1. After reset both drive flags are 0. In flow-through mode a deselect clears the drive flag after the next rising edge. In pipelined mode the flag stays high for one more edge and clears after the second.
- R2: A selected port with `*_read` = 0 writes `*_wdata` at the edge. A later read of that address on either port returns the value written.
- R3: `*_hiz` = 1 forces the port's drive flag to 0 and its data to 0 at once, with no clock edge. Returning it to 0 restores the held output.
- R4: With `*_pipe` = 0, read data for the address captured at an edge is on `*_rdata` after that same edge.
- R5: With `*_pipe` = 1, read data appears one edge later than in flow-through mode. After the first read edge of an idle port, the drive flag is still 0.
- R6: Each port's access address is set by its counter inputs, taken in this priority order:
  - `*_clear` selects word 0.
  - `*_load` selects `*_addr`.
  - `*_step` selects the previous address plus one, wrapping from DEPTH-1 to 0.
  - With none of these asserted, the previous address is held.

  The chosen address is used in the same cycle. The counter updates whether or not the port is selected. Repeated reads with no counter change return a constant value.
- R7: When one port writes an address and the other port reads that address at the same edge, the read returns the old content. A read at a later edge returns the new value.
- R8: When both ports write the same address at one edge, the left data is stored and `collide` is 1 for the cycle after that edge only. Writes to different addresses leave `collide` at 0.
- R9: A write cycle leaves the port's read data and drive flag as they were. A port that has only written stays undriven.
- R10: A deselected port writes nothing, even with `*_read` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control and output registers |
| left_cs_n | input | 1 | Left chip select, active low |
| left_cs | input | 1 | Left chip select, active high |
| left_read | input | 1 | Left access type: 1 = read, 0 = write |
| left_hiz | input | 1 | Left asynchronous output disable |
| left_pipe | input | 1 | Left latency mode: 1 = pipelined, 0 = flow-through |
| left_load | input | 1 | Left counter takes `left_addr` |
| left_step | input | 1 | Left counter advances by one |
| left_clear | input | 1 | Left counter goes to word 0 |
| left_addr | input | AW | Left external address |
| left_wdata | input | WIDTH | Left write data |
| left_rdata | output | WIDTH | Left read data, 0 when not driven |
| left_drive | output | 1 | Left output driven flag |
| right_cs_n | input | 1 | Right chip select, active low |
| right_cs | input | 1 | Right chip select, active high |
| right_read | input | 1 | Right access type: 1 = read, 0 = write |
| right_hiz | input | 1 | Right asynchronous output disable |
| right_pipe | input | 1 | Right latency mode: 1 = pipelined, 0 = flow-through |
| right_load | input | 1 | Right counter takes `right_addr` |
| right_step | input | 1 | Right counter advances by one |
| right_clear | input | 1 | Right counter goes to word 0 |
| right_addr | input | AW | Right external address |
| right_wdata | input | WIDTH | Right write data |
| right_rdata | output | WIDTH | Right read data, 0 when not driven |
| right_drive | output | 1 | Right output driven flag |
| collide | output | 1 | Both ports wrote one address at the previous edge |

## Verification
The bench fills every word through the left counter, then reads all of them back through the right counter in flow-through mode and through the left counter in pipelined mode, one word past the top. An off-by-one wrap or a missed step would show a shifted pattern, and a wrong latency would put each word one slot early or late. The same-edge cross-port read must return old data, and a design that forwarded write data would fail there. A design that let the right port win a shared write, or held `collide` high for two cycles, would show the wrong stored word or a stale flag. Further checks cover a deselected write that must change nothing, a counter step taken while deselected, a write cycle that must not disturb the output, and the extra edge a pipelined deselect takes to clear the drive flag.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  typedef enum logic [1:0] {
    CTR_HOLD  = 2'd0,
    CTR_STEP  = 2'd1,
    CTR_LOAD  = 2'd2,
    CTR_CLEAR = 2'd3
  } ctr_op_e;

  // A port acts only with its low-active select low and high-active select high.
  function automatic logic port_sel(input logic cs_n, input logic cs);
    return (!cs_n) && cs;
  endfunction

  // Clear beats load, load beats step.
  function automatic ctr_op_e ctr_decode(input logic clear, input logic load, input logic step);
    if (clear)     return CTR_CLEAR;
    else if (load) return CTR_LOAD;
    else if (step) return CTR_STEP;
    else           return CTR_HOLD;
  endfunction

endpackage

// File: rtl/dpram_addr_ctr.sv
module dpram_addr_ctr
  import dpram_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] acc_addr
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  ctr_op_e       op;
  logic [AW-1:0] cur_q;
  logic [AW-1:0] next_addr;
  logic [AW-1:0] load_addr;

  // Fold an out-of-range external address back into the array.
  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign load_addr = ext_addr;
    end else begin : g_fold
      assign load_addr = (ext_addr > LAST) ? (ext_addr - AW'(DEPTH)) : ext_addr;
    end
  endgenerate

  always_comb begin
    op = ctr_decode(clear, load, step);
    unique case (op)
      CTR_CLEAR: next_addr = '0;
      CTR_LOAD:  next_addr = load_addr;
      CTR_STEP:  next_addr = (cur_q == LAST) ? '0 : cur_q + 1'b1;
      default:   next_addr = cur_q;
    endcase
  end

  // The chosen address is used in this cycle and remembered for the next.
  assign acc_addr = next_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= next_addr;
  end

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cur_q == '0));

  // R6
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !clear) |=>
      (cur_q == (($past(cur_q) == LAST) ? '0 : $past(cur_q) + 1'b1)));

endmodule

// File: rtl/dpram_core.sv
module dpram_core #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 9,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_sel,
  input  logic             a_read,
  input  logic [AW-1:0]    a_addr,
  input  logic [WIDTH-1:0] a_wdata,
  input  logic             b_sel,
  input  logic             b_read,
  input  logic [AW-1:0]    b_addr,
  input  logic [WIDTH-1:0] b_wdata,
  output logic [WIDTH-1:0] a_rdata,
  output logic [WIDTH-1:0] b_rdata,
  output logic             collide
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic a_we, b_we;

  assign a_we = a_sel && !a_read;
  assign b_we = b_sel && !b_read;

  // The left write comes last, so it wins a shared address.
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wdata;
    if (a_we) mem[a_addr] <= a_wdata;
  end

  // Reads see the content from before this edge's writes.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
      collide <= 1'b0;
    end else begin
      if (a_sel && a_read) a_rdata <= mem[a_addr];
      if (b_sel && b_read) b_rdata <= mem[b_addr];
      collide <= a_we && b_we && (a_addr == b_addr);
    end
  end

  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_sel && !a_read) |=> $stable(a_rdata));

  // R10
  desel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !b_sel |=> $stable(b_rdata));

  // R8
  collide_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    collide |-> $past(a_sel && !a_read && b_sel && !b_read));

endmodule

// File: rtl/dpram_port_out.sv
module dpram_port_out #(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             read,
  input  logic             pipe_mode,
  input  logic             hiz,
  input  logic [WIDTH-1:0] core_data,
  output logic [WIDTH-1:0] out_data,
  output logic             out_drive
);

  logic             drive1_q;
  logic             drive2_q;
  logic [WIDTH-1:0] data2_q;
  logic             stage_drive;
  logic [WIDTH-1:0] stage_data;

  // A read turns the output on, a deselect turns it off, and a write leaves it alone.
  always_ff @(posedge clk) begin
    if (!rst_n)     drive1_q <= 1'b0;
    else if (!sel)  drive1_q <= 1'b0;
    else if (read)  drive1_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drive2_q <= 1'b0;
      data2_q  <= '0;
    end else begin
      drive2_q <= drive1_q;
      data2_q  <= core_data;
    end
  end

  assign stage_drive = pipe_mode ? drive2_q : drive1_q;
  assign stage_data  = pipe_mode ? data2_q  : core_data;
  assign out_drive   = stage_drive && !hiz;
  assign out_data    = out_drive ? stage_data : '0;

  // R1
  desel_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !sel) |=> (pipe_mode || !out_drive));

  // R1
  desel_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && !sel) |-> ##2 (!pipe_mode || !out_drive));

endmodule

// File: rtl/dpram_top.sv
module dpram_top
  import dpram_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 9,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             left_cs_n,
  input  logic             left_cs,
  input  logic             left_read,
  input  logic             left_hiz,
  input  logic             left_pipe,
  input  logic             left_load,
  input  logic             left_step,
  input  logic             left_clear,
  input  logic [AW-1:0]    left_addr,
  input  logic [WIDTH-1:0] left_wdata,
  output logic [WIDTH-1:0] left_rdata,
  output logic             left_drive,
  input  logic             right_cs_n,
  input  logic             right_cs,
  input  logic             right_read,
  input  logic             right_hiz,
  input  logic             right_pipe,
  input  logic             right_load,
  input  logic             right_step,
  input  logic             right_clear,
  input  logic [AW-1:0]    right_addr,
  input  logic [WIDTH-1:0] right_wdata,
  output logic [WIDTH-1:0] right_rdata,
  output logic             right_drive,
  output logic             collide
);

  logic             l_sel, r_sel;
  logic [AW-1:0]    l_acc, r_acc;
  logic [WIDTH-1:0] l_core, r_core;

  assign l_sel = port_sel(left_cs_n, left_cs);
  assign r_sel = port_sel(right_cs_n, right_cs);

  dpram_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_left_ctr (
    .clk(clk), .rst_n(rst_n), .clear(left_clear), .load(left_load),
    .step(left_step), .ext_addr(left_addr), .acc_addr(l_acc)
  );

  dpram_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_right_ctr (
    .clk(clk), .rst_n(rst_n), .clear(right_clear), .load(right_load),
    .step(right_step), .ext_addr(right_addr), .acc_addr(r_acc)
  );

  dpram_core #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_core (
    .clk(clk), .rst_n(rst_n),
    .a_sel(l_sel), .a_read(left_read), .a_addr(l_acc), .a_wdata(left_wdata),
    .b_sel(r_sel), .b_read(right_read), .b_addr(r_acc), .b_wdata(right_wdata),
    .a_rdata(l_core), .b_rdata(r_core), .collide(collide)
  );

  dpram_port_out #(.WIDTH(WIDTH)) u_left_out (
    .clk(clk), .rst_n(rst_n), .sel(l_sel), .read(left_read),
    .pipe_mode(left_pipe), .hiz(left_hiz), .core_data(l_core),
    .out_data(left_rdata), .out_drive(left_drive)
  );

  dpram_port_out #(.WIDTH(WIDTH)) u_right_out (
    .clk(clk), .rst_n(rst_n), .sel(r_sel), .read(right_read),
    .pipe_mode(right_pipe), .hiz(right_hiz), .core_data(r_core),
    .out_data(right_rdata), .out_drive(right_drive)
  );

endmodule

// File: tb/dpram_top_bench.sv
module dpram_top_bench;
  localparam int DEPTH = 1024;
  localparam int WIDTH = 9;
  localparam int AW    = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic l_cs_n, l_cs, l_read, l_hiz, l_pipe, l_load, l_step, l_clear;
  logic [AW-1:0] l_addr;
  logic [WIDTH-1:0] l_wdata;
  wire  [WIDTH-1:0] l_rdata;
  wire  l_drive;
  logic r_cs_n, r_cs, r_read, r_hiz, r_pipe, r_load, r_step, r_clear;
  logic [AW-1:0] r_addr;
  logic [WIDTH-1:0] r_wdata;
  wire  [WIDTH-1:0] r_rdata;
  wire  r_drive;
  wire  collide;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [WIDTH-1:0] exp_mem [DEPTH];
  logic [WIDTH-1:0] v;

  dpram_top #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_dpram_top (
    .clk(clk), .rst_n(rst_n),
    .left_cs_n(l_cs_n), .left_cs(l_cs), .left_read(l_read), .left_hiz(l_hiz),
    .left_pipe(l_pipe), .left_load(l_load), .left_step(l_step), .left_clear(l_clear),
    .left_addr(l_addr), .left_wdata(l_wdata), .left_rdata(l_rdata), .left_drive(l_drive),
    .right_cs_n(r_cs_n), .right_cs(r_cs), .right_read(r_read), .right_hiz(r_hiz),
    .right_pipe(r_pipe), .right_load(r_load), .right_step(r_step), .right_clear(r_clear),
    .right_addr(r_addr), .right_wdata(r_wdata), .right_rdata(r_rdata), .right_drive(r_drive),
    .collide(collide)
  );

  function automatic logic [WIDTH-1:0] pat(input int i);
    return WIDTH'((i * 37 + 11) % 512);
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic idle_l();
    l_cs_n = 1'b1; l_cs = 1'b1; l_read = 1'b1;
    l_load = 1'b0; l_step = 1'b0; l_clear = 1'b0;
  endtask

  task automatic idle_r();
    r_cs_n = 1'b1; r_cs = 1'b1; r_read = 1'b1;
    r_load = 1'b0; r_step = 1'b0; r_clear = 1'b0;
  endtask

  task automatic r_access(input logic rd, input int a, input logic [WIDTH-1:0] d);
    r_cs_n = 1'b0; r_cs = 1'b1; r_read = rd; r_clear = 1'b0; r_step = 1'b0;
    r_load = 1'b1; r_addr = AW'(a); r_wdata = d;
  endtask

  task automatic l_access(input logic rd, input int a, input logic [WIDTH-1:0] d);
    l_cs_n = 1'b0; l_cs = 1'b1; l_read = rd; l_clear = 1'b0; l_step = 1'b0;
    l_load = 1'b1; l_addr = AW'(a); l_wdata = d;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; l_hiz = 1'b0; r_hiz = 1'b0; l_pipe = 1'b0; r_pipe = 1'b0;
    l_addr = '0; r_addr = '0; l_wdata = '0; r_wdata = '0;
    idle_l(); idle_r();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset left drive", l_drive, 0);
    chk("R1 reset right drive", r_drive, 0);
    chk("R8 reset collide", collide, 0);

    // R2 R6: fill every word through the left counter
    for (int i = 0; i < DEPTH; i++) begin
      l_cs_n = 1'b0; l_cs = 1'b1; l_read = 1'b0; l_load = 1'b0;
      l_clear = (i == 0); l_step = (i != 0);
      l_wdata = pat(i); exp_mem[i] = pat(i);
      @(negedge clk);
    end
    chk("R9 write-only port stays undriven", l_drive, 0);
    l_clear = 1'b0; l_step = 1'b1; l_wdata = 9'h1AA; exp_mem[0] = 9'h1AA;
    @(negedge clk);
    idle_l();

    // R4 R6: flow-through sweep on right, one past the top
    for (int i = 0; i <= DEPTH; i++) begin
      r_cs_n = 1'b0; r_cs = 1'b1; r_read = 1'b1; r_clear = 1'b0;
      r_load = (i == 0); r_addr = '0; r_step = (i != 0);
      @(negedge clk);
      chk("R4 flow sweep R6 wrap", r_rdata, exp_mem[i % DEPTH]);
    end
    chk("R4 flow drive", r_drive, 1);
    idle_r();

    // R5: pipelined sweep on left
    l_pipe = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      l_cs_n = 1'b0; l_cs = 1'b1; l_read = 1'b1; l_clear = 1'b0;
      l_load = (i == 0); l_addr = '0; l_step = (i != 0);
      @(negedge clk);
      if (i == 0) chk("R5 pipe no data after first edge", l_drive, 0);
      else        chk("R5 pipe sweep", l_rdata, exp_mem[i-1]);
    end
    idle_l();
    @(negedge clk);
    chk("R5 pipe last word", l_rdata, exp_mem[DEPTH-1]);
    chk("R1 pipe deselect one edge still driven", l_drive, 1);
    @(negedge clk);
    chk("R1 pipe deselect after second edge", l_drive, 0);
    l_pipe = 1'b0;

    // R3: asynchronous output disable
    r_access(1'b1, 100, '0);
    @(negedge clk);
    chk("R3 before disable", r_rdata, exp_mem[100]);
    r_hiz = 1'b1; #1;
    chk("R3 disable drive", r_drive, 0);
    chk("R3 disable data", r_rdata, 0);
    r_hiz = 1'b0; #1;
    chk("R3 re-enable data", r_rdata, exp_mem[100]);

    // R1: deselect through the high-active select, flow mode
    r_cs = 1'b0;
    @(negedge clk);
    chk("R1 flow deselect", r_drive, 0);

    // R10 R6: deselected write, then step while deselected
    r_cs_n = 1'b1; r_cs = 1'b1; r_read = 1'b0; r_load = 1'b1; r_addr = AW'(200);
    r_wdata = ~exp_mem[200];
    @(negedge clk);
    r_load = 1'b0; r_step = 1'b1;
    @(negedge clk);
    r_cs_n = 1'b0; r_read = 1'b1; r_step = 1'b0;
    @(negedge clk);
    chk("R6 step taken while deselected", r_rdata, exp_mem[201]);
    r_access(1'b1, 200, '0);
    @(negedge clk);
    chk("R10 deselected write ignored", r_rdata, exp_mem[200]);

    // R7: cross-port read at the write edge, then after
    v = exp_mem[300] ^ 9'h155;
    l_access(1'b0, 300, v);
    r_access(1'b1, 300, '0);
    @(negedge clk);
    chk("R7 same-edge read old data", r_rdata, exp_mem[300]);
    exp_mem[300] = v;
    idle_l();
    @(negedge clk);
    chk("R7 later read new data", r_rdata, v);

    // R8: same-address double write
    l_access(1'b0, 400, 9'h0F0);
    r_access(1'b0, 400, 9'h10F);
    @(negedge clk);
    chk("R8 collide raised", collide, 1);
    exp_mem[400] = 9'h0F0;
    idle_l(); idle_r();
    @(negedge clk);
    chk("R8 collide one cycle", collide, 0);
    r_access(1'b1, 400, '0);
    @(negedge clk);
    chk("R8 left data stored", r_rdata, 9'h0F0);
    l_access(1'b0, 401, 9'h033);
    r_access(1'b0, 402, 9'h044);
    @(negedge clk);
    chk("R8 distinct addresses no collide", collide, 0);
    exp_mem[401] = 9'h033; exp_mem[402] = 9'h044;
    idle_l();

    // R9: a write cycle keeps the last read output
    r_access(1'b1, 500, '0);
    @(negedge clk);
    chk("R9 read before write", r_rdata, exp_mem[500]);
    r_access(1'b0, 501, 9'h1C3);
    @(negedge clk);
    chk("R9 data held in write", r_rdata, exp_mem[500]);
    chk("R9 drive held in write", r_drive, 1);
    exp_mem[501] = 9'h1C3;

    // R2: same-port readback
    r_access(1'b1, 501, '0);
    @(negedge clk);
    chk("R2 readback", r_rdata, 9'h1C3);
    chk("R2 readback left", l_drive, 0);

    // R6: counter priority and hold
    r_access(1'b1, 5, '0);
    r_clear = 1'b1; r_step = 1'b1;
    @(negedge clk);
    chk("R6 clear wins", r_rdata, exp_mem[0]);
    r_clear = 1'b0; r_addr = AW'(7);
    @(negedge clk);
    chk("R6 load beats step", r_rdata, exp_mem[7]);
    r_load = 1'b0; r_step = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R6 hold keeps output constant", r_rdata, exp_mem[7]);
    idle_r();
    @(negedge clk);

    done = 1'b1;
    finish_run();
  end

endmodule